// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave with Programming Lockout

This block is the target side of a two-wire (I2C) serial bus in front of a byte-wide internal memory of 256 locations. A fast system clock oversamples the clock and data wires. The block recognises bus start and stop events and answers to one fixed device address. It keeps a word pointer and supports single-byte writes and reads of any length. The data wire is open drain: the block only ever pulls it low, through an output-enable pin.

A write commits only when the master closes it with a stop. That stop starts a timed programming interval, and the `busy` output is high for all of it. While it lasts the block answers no request at all, so a master polls the device address until it is acknowledged again. A read returns bytes from the current pointer for as long as the master acknowledges them. A master non-acknowledge makes the block go silent until the next stop or start.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset `sdaOe` is 0, `busy` is 0, the word pointer is 0x00 and every memory location reads back as 0x00.
- R2: The first byte after a start is received MSB first. It is seven address bits followed by a direction bit (0 write, 1 read). Only the address 1010000 is acknowledged, by pulling SDA low through the ninth clock. Any other address is left unacknowledged, and every later byte is ignored until the next start or stop.
- R3: In a write, the byte after the device address loads the word pointer. Every received byte is acknowledged on its ninth clock.
- R4: A stop that follows at least one complete data byte stores that byte and holds `busy` high for `PROG_CYCLES` system clocks.
- R5: While `busy` is high the device address is not acknowledged. Once `busy` falls it is acknowledged again.
- R6: In a read, the block drives the byte at the pointer MSB first and releases SDA for the ninth clock. A master acknowledge continues the read with the next location.
- R7: A master non-acknowledge on the ninth clock of a read byte leaves SDA released until the next start or stop.
- R8: The pointer advances by one after every byte read or written and wraps from 0xFF to 0x00. A read that has no word-address phase begins at the current pointer.
- R9: A start or stop that arrives in the middle of a byte, or before the stop that would close a write, discards the pending write. A start then returns the block to address matching.
- R10: The block changes the SDA drive only while SCL is low.
- R11: When several data bytes follow one word address, each is acknowledged. Only the last one is stored, at the pointer value that byte was received at.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock wire level |
| sdaIn | input | 1 | Bus data wire level (the resolved open-drain line) |
| sdaOe | output | 1 | High to pull the data wire low |
| busy | output | 1 | High during the programming interval |

## Verification
All 128 seven-bit device addresses are tried with the write bit. This shows that exactly one address is claimed, and that a refused transaction keeps SDA released on the bytes that follow. Byte writes go to spread-out locations, including 0xFF. A read that wraps past 0xFF and a sweep that reads all 256 locations then tell a correct store and pointer advance apart from off-by-one or wrap faults. Separate patterns cover the following:
- a run of several data bytes before the stop, which separates "last byte wins" from page-style storing;
- an address poll inside the programming window;
- a master non-acknowledge followed by extra clocks;
- starts and stops placed in the middle of a byte, which separate an aborted write from a committed one.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } busState_t;

  typedef struct packed {
    logic shiftRx;
    logic loadPtr;
    logic capture;
    logic commit;
    logic loadTx;
    logic shiftTx;
    logic incPtr;
  } memStrobe_t;

endpackage

// File: rtl/bus_edge_sampler.sv
module bus_edge_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLevel,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLevel;
      sdaPrev <= sdaLevel;
    end
  end

  assign sclLevel = sclPipe[SYNC_STAGES-1];
  assign sdaLevel = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclLevel && !sclPrev;
  assign sclFall  = !sclLevel && sclPrev;
  assign startDet = sclLevel && sclPrev && sdaPrev && !sdaLevel;
  assign stopDet  = sclLevel && sclPrev && !sdaPrev && sdaLevel;

endmodule

// File: rtl/mem_datapath.sv
module mem_datapath
  import serial_mem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strb,
  input  logic              sdaLevel,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic              busy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] txShift;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] pendAddr;
  logic [BYTE_W-1:0] pendData;
  logic [CNT_W-1:0]  progCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      txShift  <= '0;
      ptr      <= '0;
      pendAddr <= '0;
      pendData <= '0;
    end else begin
      if (strb.shiftRx) rxByte <= {rxByte[BYTE_W-2:0], sdaLevel};
      if (strb.loadTx) txShift <= mem[ptr];
      else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (strb.loadPtr) ptr <= rxByte[ADDR_W-1:0];
      else if (strb.capture || strb.incPtr) ptr <= ptr + 1'b1;
      if (strb.capture) begin
        pendAddr <= ptr;
        pendData <= rxByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.commit) begin
      mem[pendAddr] <= pendData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      progCnt <= '0;
    end else if (strb.commit) begin
      busy    <= 1'b1;
      progCnt <= PROG_LAST;
    end else if (busy) begin
      if (progCnt == '0) busy <= 1'b0;
      else progCnt <= progCnt - 1'b1;
    end
  end

  assign txMsb = txShift[BYTE_W-1];

  // R4: the stop that commits a write opens the programming window
  p_commit_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> busy);

  // R5: no data byte is taken in while programming
  p_no_capture_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.capture);

  // R8: the pointer wraps from the top location to zero
  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incPtr && !strb.loadPtr && ptr == '1) |=> ptr == '0);

endmodule

// File: rtl/mem_ctrl.sv
module mem_ctrl
  import serial_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclLevel,
  input  logic              sdaLevel,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic              busy,
  output memStrobe_t        strb,
  output logic              sdaOe
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  busState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic             ackDrive;
  logic             isRead;
  logic             pending;
  logic             masterAck;
  logic             noEvent;
  logic             byteDone;
  logic             rxState;
  logic             addrHit;

  assign noEvent  = !startDet && !stopDet;
  assign byteDone = (bitCnt == LAST_BIT);
  assign rxState  = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_WDATA);
  assign addrHit  = (rxByte[BYTE_W-1:1] == DEV_ADDR) && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      isRead    <= 1'b0;
      pending   <= 1'b0;
      masterAck <= 1'b0;
    end else if (startDet) begin
      state    <= ST_DEV;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      pending  <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      pending  <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && byteDone) begin
            bitCnt <= '0;
            if (state == ST_DEV) begin
              if (addrHit) begin
                ackDrive <= 1'b1;
                isRead   <= rxByte[0];
                state    <= ST_DEV_ACK;
              end else begin
                state <= ST_WAIT;
              end
            end else if (state == ST_WADDR) begin
              ackDrive <= 1'b1;
              state    <= ST_WADDR_ACK;
            end else begin
              ackDrive <= 1'b1;
              pending  <= 1'b1;
              state    <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: if (sclFall) begin
          ackDrive <= 1'b0;
          state    <= isRead ? ST_RDATA : ST_WADDR;
        end
        ST_WADDR_ACK, ST_WDATA_ACK: if (sclFall) begin
          ackDrive <= 1'b0;
          state    <= ST_WDATA;
        end
        ST_RDATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && byteDone) begin
            bitCnt <= '0;
            state  <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (sclRise) masterAck <= !sdaLevel;
          else if (sclFall) state <= masterAck ? ST_RDATA : ST_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.shiftRx = noEvent && sclRise && rxState;
    strb.loadPtr = noEvent && sclFall && byteDone && (state == ST_WADDR);
    strb.capture = noEvent && sclFall && byteDone && (state == ST_WDATA);
    strb.commit  = stopDet && pending;
    strb.loadTx  = noEvent && sclFall &&
                   (((state == ST_DEV_ACK) && isRead) || ((state == ST_RACK) && masterAck));
    strb.shiftTx = noEvent && sclFall && (state == ST_RDATA) && !byteDone;
    strb.incPtr  = noEvent && sclFall && (state == ST_RDATA) && byteDone;
  end

  assign sdaOe = ackDrive || ((state == ST_RDATA) && !txMsb);

  // R10: drive changes follow a low clock unless a bus event forced them
  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(startDet) && !$past(stopDet)) |-> !$past(sclLevel));

  // R7: after a refused address or a master NACK the line stays released
  p_wait_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> !sdaOe);

  // R5: no acknowledge begins during programming
  p_no_ack_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> !busy);

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import serial_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter int         ADDR_W      = 8,
  parameter int         PROG_CYCLES = 625000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  output logic busy
);

  logic sclLevel, sdaLevel, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] rxByte;
  logic txMsb;
  memStrobe_t strb;

  bus_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  mem_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .sdaLevel(sdaLevel),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .txMsb(txMsb), .busy(busy), .strb(strb), .sdaOe(sdaOe)
  );

  mem_datapath #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaLevel(sdaLevel),
    .rxByte(rxByte), .txMsb(txMsb), .busy(busy)
  );

endmodule

// File: tb/tb_serial_mem_slave.sv
module tb_serial_mem_slave;

  localparam int Q    = 6;
  localparam int PROG = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe, busy;
  logic sdaLine;
  logic oePrev = 1'b0;
  int total = 0;
  int bad = 0;
  int oeViol = 0;
  int expPtr = 0;
  logic [7:0] expMem [256];

  assign sdaLine = sdaM & ~sdaOe;
  always #4 clk = ~clk;

  serial_mem_slave #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .busy(busy)
  );

  // R10 monitor: the drive must never move while the bench holds SCL high
  always @(negedge clk) begin
    if (rstN && (sdaOe !== oePrev) && sclM) oeViol++;
    oePrev = sdaOe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic startC();
    sdaM = 1'b1; qw(); sclM = 1'b1; qw(); sdaM = 1'b0; qw(); sclM = 1'b0; qw();
  endtask

  task automatic stopC();
    sclM = 1'b0; sdaM = 1'b0; qw(); sclM = 1'b1; qw(); sdaM = 1'b1; qw();
  endtask

  task automatic bitC(input logic b, output logic s);
    sdaM = b; qw(); sclM = 1'b1; qw(); s = sdaLine; qw(); sclM = 1'b0; qw();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitC(b[i], s);
    bitC(1'b1, s);
    ack = !s;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bitC(1'b1, s);
      d = {d[6:0], s};
    end
    bitC(!giveAck, s);
  endtask

  task automatic byteWrite(input int a, input logic [7:0] d);
    bit ack;
    startC();
    sendByte(8'hA0, ack); check(ack, "R2 write address ack", ack, 1);
    sendByte(a[7:0], ack); check(ack, "R3 word address ack", ack, 1);
    sendByte(d, ack);      check(ack, "R3 data ack", ack, 1);
    stopC();
    expMem[a] = d;
    expPtr = (a + 1) % 256;
    check(busy == 1'b1, "R4 busy after stop", busy, 1);
    repeat (PROG + 20) @(negedge clk);
    check(busy == 1'b0, "R4 busy cleared", busy, 0);
  endtask

  // read n bytes; if setAddr, a word address phase first loads a
  task automatic readBytes(input bit setAddr, input int a, input int n, input string req);
    bit ack;
    logic [7:0] d;
    startC();
    if (setAddr) begin
      sendByte(8'hA0, ack); check(ack, "R2 write address ack", ack, 1);
      sendByte(a[7:0], ack); check(ack, "R3 word address ack", ack, 1);
      expPtr = a;
      startC();
    end
    sendByte(8'hA1, ack); check(ack, "R6 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, d);
      check(d == expMem[expPtr], req, d, expMem[expPtr]);
      expPtr = (expPtr + 1) % 256;
    end
    stopC();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack;
    logic s;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) expMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(sdaOe == 1'b0, "R1 sdaOe reset", sdaOe, 0);
    check(busy == 1'b0, "R1 busy reset", busy, 0);
    readBytes(1'b0, 0, 4, "R1 R8 reset contents at pointer 0");

    // R2: sweep every device address with the write bit
    for (int a = 0; a < 128; a++) begin
      startC();
      sendByte({a[6:0], 1'b0}, ack);
      check(ack == (a == 8'h50), "R2 address sweep", ack, (a == 8'h50));
      if (a != 8'h50 && a[3:0] == 4'h0) begin
        sendByte(8'h00, ack);
        check(!ack, "R2 ignored after refusal", ack, 0);
      end
      stopC();
    end

    // R4: exact length of the programming window
    startC();
    sendByte(8'hA0, ack); sendByte(8'h10, ack); sendByte(8'hC3, ack);
    stopC();
    expMem[16] = 8'hC3; expPtr = 17;
    repeat (PROG - 12) @(negedge clk);
    check(busy == 1'b1, "R4 busy held", busy, 1);
    repeat (15) @(negedge clk);
    check(busy == 1'b0, "R4 busy ends", busy, 0);

    // R3 R4: byte writes across the space
    for (int k = 0; k < 16; k++) begin
      int a;
      a = (k * 37 + 5) % 256;
      byteWrite(a, 8'((a * 3 + 7) ^ 8'hA5));
    end
    byteWrite(255, 8'h7E);

    // R5: poll during programming is refused, accepted afterwards
    startC();
    sendByte(8'hA0, ack); sendByte(8'h20, ack); sendByte(8'h4D, ack);
    stopC();
    expMem[32] = 8'h4D; expPtr = 33;
    startC();
    sendByte(8'hA0, ack);
    check(!ack, "R5 refused while busy", ack, 0);
    stopC();
    check(busy == 1'b1, "R5 still busy", busy, 1);
    repeat (PROG) @(negedge clk);
    startC();
    sendByte(8'hA0, ack);
    check(ack, "R5 accepted after busy", ack, 1);
    stopC();

    // R8: current-address read after a write
    byteWrite(128, 8'h3C);
    byteWrite(129, 8'hD2);
    readBytes(1'b0, 0, 1, "R8 current address read");

    // R6 R8: read across the wrap
    readBytes(1'b1, 240, 32, "R6 R8 wrap read");

    // R11: several data bytes, last one wins
    startC();
    sendByte(8'hA0, ack);
    sendByte(8'h40, ack);
    sendByte(8'h11, ack); check(ack, "R11 first data ack", ack, 1);
    sendByte(8'h22, ack); check(ack, "R11 second data ack", ack, 1);
    sendByte(8'h33, ack); check(ack, "R11 third data ack", ack, 1);
    stopC();
    expMem[66] = 8'h33;
    repeat (PROG + 20) @(negedge clk);
    readBytes(1'b1, 64, 4, "R11 last byte stored");

    // R7: master NACK silences the block
    readBytes(1'b1, 16, 0, "R7 setup");
    startC();
    sendByte(8'hA1, ack);
    recvByte(1'b0, d);
    check(d == expMem[16], "R7 byte before NACK", d, expMem[16]);
    for (int i = 0; i < 9; i++) begin
      bitC(1'b1, s);
      check(s == 1'b1, "R7 released after NACK", s, 1);
    end
    stopC();
    expPtr = 17;
    readBytes(1'b0, 0, 1, "R7 R8 pointer after NACK");

    // R9: repeated start inside a data byte
    startC();
    sendByte(8'hA0, ack); sendByte(8'h60, ack);
    for (int i = 0; i < 4; i++) bitC(1'b1, s);
    startC();
    sendByte(8'hA1, ack);
    check(ack, "R9 address match after abort", ack, 1);
    recvByte(1'b0, d);
    check(d == expMem[96], "R9 pointer kept, data untouched", d, expMem[96]);
    stopC();
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R9 no programming after abort", busy, 0);

    // R9: stop inside a data byte
    startC();
    sendByte(8'hA0, ack); sendByte(8'h61, ack);
    for (int i = 0; i < 3; i++) bitC(1'b0, s);
    stopC();
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R9 no programming after mid-byte stop", busy, 0);

    // R9: complete data byte then start instead of stop
    startC();
    sendByte(8'hA0, ack); sendByte(8'h62, ack); sendByte(8'h99, ack);
    startC();
    stopC();
    repeat (10) @(negedge clk);
    check(busy == 1'b0, "R9 pending write discarded", busy, 0);
    readBytes(1'b1, 96, 4, "R9 memory unchanged");

    // R1 R3 R6: full sweep of all locations
    readBytes(1'b1, 0, 256, "R6 full memory sweep");

    check(oeViol == 0, "R10 drive changed with SCL high", oeViol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule